// File: doc/BRIEF.md
# UART receiver with status-tagged receive queue

This block turns an asynchronous serial receive line into parallel words and keeps them in a small receive queue. Every queue entry is 12 bits wide. Up to 9 bits carry the received data. The top three bits record what went wrong with that particular word: a parity mismatch, a stop bit found low, or disagreement between the three samples of any bit. Software can therefore tell a bad word from a good one long after it arrived, without matching separate status registers to queue positions.

The line is sampled on a 16x oversampling tick that the surrounding logic supplies. A falling edge starts a frame. The start bit is confirmed at mid-bit, and every later bit is decided by a majority vote over three samples near its centre. The frame geometry is a configuration input: the word length code selects 7, 8 or 9 bits, and an optional parity bit sits in the last of those positions. With queueing turned off, the same storage acts as a single holding register. A word that finds no free room is dropped and raises a sticky overrun indicator. The indicator stays up until the user clears it.

Top module: `uart_rx_tagfifo`

## Requirements
- R1: After reset the queue is empty (`rd_empty` = 1) and `ovr_flag` = 0.
- R2: `cfg_len` selects the number of bits after the start bit, sent least significant bit first: 2'b00 gives 8, 2'b01 gives 9, 2'b10 gives 7 (2'b11 behaves as 2'b00). The bits land in entry bits [8:0], and entry bits above the word length read 0.
- R3: With `cfg_par_en` = 1, the last bit of the selected word length is the parity bit. It is returned as 0 in the data field. Entry bit 9 is set when the ones count over all received word bits, parity included, is odd while `cfg_par_odd` = 0, or even while `cfg_par_odd` = 1.
- R4: A stop bit that votes low sets entry bit 10. A word with all data bits 0 and a low stop bit (a break) is stored as such, with value 12'h400.
- R5: Each bit is sampled at ticks 7, 8 and 9 of its 16 ticks and decided by majority. Any disagreement among the three samples of a data, parity or stop bit sets entry bit 11 and does not alter the data.
- R6: A low pulse that is back high by the mid-bit samples of the start bit stores nothing, and the receiver then takes the next frame normally.
- R7: Entries are read in arrival order. `rd_entry` shows the oldest entry while `rd_empty` = 0, and a one-cycle `rd_en` removes it. `rd_en` while empty changes nothing.
- R8: With `cfg_fifo_en` = 1 the queue holds `FIFO_DEPTH` entries. With `cfg_fifo_en` = 0 it holds one.
- R9: A word completed while the queue is at capacity is discarded and sets `ovr_flag`. The flag stays set until a cycle with `ovr_clr` = 1 and no new discard.
- R10: A frame whose start bit begins within one tick of the previous stop bit's end is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial receive line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_len | input | 2 | Word length code |
| cfg_par_en | input | 1 | Parity bit present in the last word position |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_fifo_en | input | 1 | 1 uses the full queue, 0 a single holding entry |
| rd_en | input | 1 | Read strobe, pops the oldest entry |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rd_entry | output | 12 | Oldest entry: noise[11], framing[10], parity[9], data[8:0] |
| rd_empty | output | 1 | Queue holds no entry |
| ovr_flag | output | 1 | Sticky overrun indicator |

## Verification
Frames are sent with each length code, with and without parity of both kinds. A correct parity bit and a deliberately wrong one separate a parity check that tracks the configured sense from one fixed at even. A low stop bit with a non-zero payload and a break frame check that framing status and the data field are independent. A single flipped centre sample shows that voting restores the bit while the noise flag is still raised. A short low glitch, three frames sent back to back, an over-full queue in both queueing modes and a read of the empty queue exercise start qualification, mid-stop commit, capacity selection and the sticky overrun flag.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int DATA_W  = 9;
  localparam int ENTRY_W = 12;

  typedef enum logic [1:0] {
    LEN_8B  = 2'b00,
    LEN_9B  = 2'b01,
    LEN_7B  = 2'b10,
    LEN_RSV = 2'b11
  } len_code_e;

  typedef struct packed {
    logic              noise;
    logic              frame_err;
    logic              par_err;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  function automatic logic [3:0] len_to_bits(input logic [1:0] code);
    case (code)
      LEN_9B:  return 4'd9;
      LEN_7B:  return 4'd7;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_bitsamp.sv
module uart_rx_bitsamp #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  input  logic rx,
  output logic mid_vld,
  output logic mid_bit,
  output logic mid_noise
);

  localparam int CW    = $clog2(OSR);
  localparam int MID   = OSR / 2;
  localparam int LO_I  = MID - 1;
  localparam int HI_I  = MID + 1;
  localparam int LST_I = OSR - 1;
  localparam logic [CW-1:0] S_LO  = LO_I[CW-1:0];
  localparam logic [CW-1:0] S_MID = MID[CW-1:0];
  localparam logic [CW-1:0] S_HI  = HI_I[CW-1:0];
  localparam logic [CW-1:0] LAST  = LST_I[CW-1:0];

  logic [CW-1:0] cnt;
  logic          smp_a;
  logic          smp_b;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt       <= '0;
      smp_a     <= 1'b1;
      smp_b     <= 1'b1;
      mid_vld   <= 1'b0;
      mid_bit   <= 1'b1;
      mid_noise <= 1'b0;
    end else begin
      mid_vld <= 1'b0;
      if (tick) begin
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        if (cnt == S_LO)  smp_a <= rx;
        if (cnt == S_MID) smp_b <= rx;
        if (cnt == S_HI) begin
          mid_vld   <= 1'b1;
          mid_bit   <= (smp_a & smp_b) | (smp_a & rx) | (smp_b & rx);
          mid_noise <= (smp_a != smp_b) || (smp_b != rx);
        end
      end
    end
  end

endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            os_tick,
  input  logic            rx,
  input  logic [1:0]      cfg_len,
  input  logic            cfg_par_en,
  input  logic            cfg_par_odd,
  output logic            word_vld,
  output rx_entry_t       word,
  output logic [1:0]      word_len,
  output logic            word_par
);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} st_e;

  st_e               st;
  logic              rx_prev;
  logic              restart;
  logic              mid_vld;
  logic              mid_bit;
  logic              mid_noise;
  logic [3:0]        idx;
  logic [3:0]        nbits;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] par_mask;
  logic              noise_acc;
  logic              par_odd_q;

  assign restart  = (st == ST_IDLE) && rx_prev && !rx;
  assign nbits    = len_to_bits(word_len);
  assign par_mask = DATA_W'(1) << (nbits - 4'd1);

  uart_rx_bitsamp #(.OSR(OSR)) u_samp (
    .clk       (clk),
    .rst       (rst),
    .tick      (os_tick),
    .restart   (restart),
    .rx        (rx),
    .mid_vld   (mid_vld),
    .mid_bit   (mid_bit),
    .mid_noise (mid_noise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      rx_prev   <= 1'b1;
      idx       <= '0;
      shreg     <= '0;
      noise_acc <= 1'b0;
      par_odd_q <= 1'b0;
      word_len  <= LEN_8B;
      word_par  <= 1'b0;
      word_vld  <= 1'b0;
      word      <= '0;
    end else begin
      rx_prev  <= rx;
      word_vld <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (restart) begin
            st        <= ST_START;
            word_len  <= cfg_len;
            word_par  <= cfg_par_en;
            par_odd_q <= cfg_par_odd;
          end
        end
        ST_START: begin
          if (mid_vld) begin
            if (mid_bit) begin
              st <= ST_IDLE;
            end else begin
              st        <= ST_DATA;
              idx       <= '0;
              shreg     <= '0;
              noise_acc <= 1'b0;
            end
          end
        end
        ST_DATA: begin
          if (mid_vld) begin
            shreg[idx] <= mid_bit;
            noise_acc  <= noise_acc | mid_noise;
            if (idx == nbits - 4'd1) st <= ST_STOP;
            else                     idx <= idx + 4'd1;
          end
        end
        default: begin
          if (mid_vld) begin
            word_vld       <= 1'b1;
            word.data      <= word_par ? (shreg & ~par_mask) : shreg;
            word.par_err   <= word_par && ((^shreg) != par_odd_q);
            word.frame_err <= !mid_bit;
            word.noise     <= noise_acc | mid_noise;
            st             <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         deep_mode,
  input  logic         wr_vld,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full,
  output logic         drop
);

  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LST_I = DEPTH - 1;
  localparam logic [AW:0]   CAP_DEEP = DEPTH[AW:0];
  localparam logic [AW:0]   CAP_ONE  = {{AW{1'b0}}, 1'b1};
  localparam logic [AW-1:0] LAST_PTR = LST_I[AW-1:0];

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [AW:0]   count;
  logic [AW:0]   count_nxt;
  logic          push;
  logic          pop;

  assign full  = count >= (deep_mode ? CAP_DEEP : CAP_ONE);
  assign push  = wr_vld && !full;
  assign drop  = wr_vld && full;
  assign pop   = rd_en && !empty;

  always_comb begin
    count_nxt = count;
    if (push && !pop) count_nxt = count + 1'b1;
    if (pop && !push) count_nxt = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      empty  <= 1'b1;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      count <= count_nxt;
      empty <= (count_nxt == '0);
    end
  end

  assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/uart_rx_tagfifo.sv
module uart_rx_tagfifo
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_line,
  input  logic               os_tick,
  input  logic [1:0]         cfg_len,
  input  logic               cfg_par_en,
  input  logic               cfg_par_odd,
  input  logic               cfg_fifo_en,
  input  logic               rd_en,
  input  logic               ovr_clr,
  output logic [ENTRY_W-1:0] rd_entry,
  output logic               rd_empty,
  output logic               ovr_flag
);

  logic               rx_s;
  logic               word_vld;
  rx_entry_t          word;
  logic [ENTRY_W-1:0] word_bits;
  logic [1:0]         word_len;
  logic               word_par;
  logic               fifo_full;
  logic               fifo_drop;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_line),
    .dout (rx_s)
  );

  uart_rx_deser #(.OSR(OSR)) u_deser (
    .clk         (clk),
    .rst         (rst),
    .os_tick     (os_tick),
    .rx          (rx_s),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .word_vld    (word_vld),
    .word        (word),
    .word_len    (word_len),
    .word_par    (word_par)
  );

  assign word_bits = word;

  uart_rx_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .deep_mode (cfg_fifo_en),
    .wr_vld    (word_vld),
    .wr_data   (word_bits),
    .rd_en     (rd_en),
    .rd_data   (rd_entry),
    .empty     (rd_empty),
    .full      (fifo_full),
    .drop      (fifo_drop)
  );

  always_ff @(posedge clk) begin
    if (rst)            ovr_flag <= 1'b0;
    else if (fifo_drop) ovr_flag <= 1'b1;
    else if (ovr_clr)   ovr_flag <= 1'b0;
  end

endmodule

// File: rtl/uart_rx_tagfifo_chk.sv
module uart_rx_tagfifo_chk (
  input logic        clk,
  input logic        rst,
  input logic        rd_en,
  input logic        ovr_clr,
  input logic        rd_empty,
  input logic        ovr_flag,
  input logic        word_vld,
  input logic [11:0] word,
  input logic [1:0]  word_len,
  input logic        word_par,
  input logic        fifo_full
);

  // R1: reset leaves an empty queue and a clear overrun flag
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_empty && !ovr_flag));

  // R2: bits above a 7-bit word read zero
  a_r2_len7_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (word_vld && word_len == 2'b10) |-> (word[8:7] == 2'b00));

  // R2: bit 8 reads zero for an 8-bit word
  a_r2_len8_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (word_vld && word_len == 2'b00) |-> (word[8] == 1'b0));

  // R3: the parity position of a 9-bit word is not returned as data
  a_r3_parity_hidden: assert property (@(posedge clk) disable iff (rst)
    (word_vld && word_par && word_len == 2'b01) |-> (word[8] == 1'b0));

  // R7: without a new word an empty queue stays empty, reads included
  a_r7_empty_holds: assert property (@(posedge clk) disable iff (rst)
    (rd_empty && !word_vld) |=> rd_empty);

  // R9: the overrun flag only rises after a word met a full queue
  a_r9_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_flag) |-> $past(word_vld && fifo_full));

  // R9: the overrun flag is sticky until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

endmodule

bind uart_rx_tagfifo uart_rx_tagfifo_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_en     (rd_en),
  .ovr_clr   (ovr_clr),
  .rd_empty  (rd_empty),
  .ovr_flag  (ovr_flag),
  .word_vld  (word_vld),
  .word      (word_bits),
  .word_len  (word_len),
  .word_par  (word_par),
  .fifo_full (fifo_full)
);

// File: tb/uart_rx_tagfifo_bench.sv
module uart_rx_tagfifo_bench;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx  = 1'b1;
  logic        os_tick;
  logic [1:0]  tdiv;
  logic [1:0]  cfg_len = 2'b00;
  logic        cfg_par_en = 1'b0;
  logic        cfg_par_odd = 1'b0;
  logic        cfg_fifo_en = 1'b1;
  logic        rd_en = 1'b0;
  logic        ovr_clr = 1'b0;
  logic [11:0] rd_entry;
  logic        rd_empty;
  logic        ovr_flag;

  int          checks = 0;
  int          failures = 0;
  bit          quiet = 1'b0;
  bit          done = 1'b0;
  bit          ovr_m = 1'b0;
  bit          fen_m = 1'b1;
  logic [11:0] q[$];

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) tdiv <= 2'd0;
    else     tdiv <= tdiv + 2'd1;
  end
  assign os_tick = (tdiv == 2'd3);

  uart_rx_tagfifo #(.FIFO_DEPTH(DEPTH)) u_uart_rx_tagfifo (
    .clk         (clk),
    .rst         (rst),
    .rx_line     (rx),
    .os_tick     (os_tick),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .cfg_fifo_en (cfg_fifo_en),
    .rd_en       (rd_en),
    .ovr_clr     (ovr_clr),
    .rd_entry    (rd_entry),
    .rd_empty    (rd_empty),
    .ovr_flag    (ovr_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // reference model compared every clock while the line is quiet
  always @(posedge clk) begin
    #3;
    if (!rst && quiet && !done) begin
      check(rd_empty == (q.size() == 0), "R7", "empty flag", int'(rd_empty), int'(q.size() == 0));
      check(ovr_flag == ovr_m, "R9", "overrun flag", int'(ovr_flag), int'(ovr_m));
      if (q.size() != 0)
        check(rd_entry == q[0], "R7", "head entry", int'(rd_entry), int'(q[0]));
    end
  end

  task automatic wait_tick();
    @(posedge clk);
    while (os_tick !== 1'b1) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic v, input bit flip);
    for (int t = 0; t < 16; t++) begin
      rx = (flip && t == 8) ? ~v : v;
      wait_tick();
    end
  endtask

  task automatic push_model(input logic [11:0] e);
    int cap;
    cap = fen_m ? DEPTH : 1;
    if (q.size() < cap) q.push_back(e);
    else                ovr_m = 1'b1;
  endtask

  task automatic rx_word(input logic [8:0] d, input logic [1:0] code, input bit pen,
                         input bit odd, input bit bad, input bit stop_v,
                         input int noise_pos, input int gap);
    int          nb;
    logic [8:0]  raw;
    logic [11:0] e;
    nb  = (code == 2'b01) ? 9 : (code == 2'b10) ? 7 : 8;
    raw = '0;
    for (int i = 0; i < nb; i++) raw[i] = d[i];
    if (pen) begin
      raw[nb-1] = 1'b0;
      raw[nb-1] = (^raw) ^ odd ^ bad;
    end
    e[8:0] = raw;
    if (pen) e[nb-1] = 1'b0;
    e[9]  = pen && bad;
    e[10] = !stop_v;
    e[11] = (noise_pos >= 0);
    quiet = 1'b0;
    wait_tick();
    cfg_len     = code;
    cfg_par_en  = pen;
    cfg_par_odd = odd;
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < nb; i++) send_bit(raw[i], i == noise_pos);
    send_bit(stop_v, 1'b0);
    rx = 1'b1;
    for (int i = 0; i < gap; i++) wait_tick();
    push_model(e);
    quiet = 1'b1;
  endtask

  task automatic false_start();
    quiet = 1'b0;
    wait_tick();
    rx = 1'b0;
    repeat (4) wait_tick();
    rx = 1'b1;
    repeat (24) wait_tick();
    quiet = 1'b1;
  endtask

  task automatic read_check(input string req, input logic [11:0] exp_e);
    @(negedge clk);
    check(!rd_empty, req, "queue not empty", int'(rd_empty), 0);
    check(rd_entry == exp_e, req, "entry value", int'(rd_entry), int'(exp_e));
    rd_en = 1'b1;
    if (q.size() != 0) void'(q.pop_front());
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic clear_ovr();
    @(negedge clk);
    ovr_clr = 1'b1;
    ovr_m   = 1'b0;
    @(negedge clk);
    ovr_clr = 1'b0;
  endtask

  task automatic set_fifo(input bit v);
    @(negedge clk);
    cfg_fifo_en = v;
    fen_m       = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rd_empty == 1'b1, "R1", "empty after reset", int'(rd_empty), 1);
    check(ovr_flag == 1'b0, "R1", "overrun after reset", int'(ovr_flag), 0);
    quiet = 1'b1;

    // R2: the three word lengths
    rx_word(9'h0A5, 2'b00, 0, 0, 0, 1, -1, 2);
    rx_word(9'h03C, 2'b00, 0, 0, 0, 1, -1, 2);
    read_check("R2", 12'h0A5);
    read_check("R7", 12'h03C);
    rx_word(9'h1C3, 2'b01, 0, 0, 0, 1, -1, 2);
    read_check("R2", 12'h1C3);
    rx_word(9'h0FF, 2'b10, 0, 0, 0, 1, -1, 2);
    read_check("R2", 12'h07F);

    // R3: even and odd parity, correct and wrong
    rx_word(9'h055, 2'b00, 1, 0, 0, 1, -1, 2);
    read_check("R3", 12'h055);
    rx_word(9'h055, 2'b00, 1, 0, 1, 1, -1, 2);
    read_check("R3", 12'h255);
    rx_word(9'h0AB, 2'b01, 1, 1, 0, 1, -1, 2);
    read_check("R3", 12'h0AB);
    rx_word(9'h1AB, 2'b01, 1, 1, 1, 1, -1, 2);
    read_check("R3", 12'h2AB);

    // R4: framing error and break
    rx_word(9'h012, 2'b00, 0, 0, 0, 0, -1, 2);
    read_check("R4", 12'h412);
    rx_word(9'h000, 2'b00, 0, 0, 0, 0, -1, 2);
    read_check("R4", 12'h400);

    // R5: one disturbed centre sample
    rx_word(9'h00F, 2'b00, 0, 0, 0, 1, 3, 2);
    read_check("R5", 12'h80F);
    rx_word(9'h00F, 2'b00, 0, 0, 0, 1, 6, 2);
    read_check("R5", 12'h80F);

    // R6: glitch rejected, then a clean frame
    false_start();
    @(negedge clk);
    check(rd_empty == 1'b1, "R6", "glitch stored nothing", int'(rd_empty), 1);
    rx_word(9'h081, 2'b00, 0, 0, 0, 1, -1, 2);
    read_check("R6", 12'h081);

    // R10: frames back to back
    rx_word(9'h011, 2'b00, 0, 0, 0, 1, -1, 0);
    rx_word(9'h022, 2'b00, 0, 0, 0, 1, -1, 0);
    rx_word(9'h033, 2'b00, 0, 0, 0, 1, -1, 2);
    read_check("R10", 12'h011);
    read_check("R10", 12'h022);
    read_check("R10", 12'h033);

    // R7: read while empty
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    check(rd_empty == 1'b1, "R7", "read on empty", int'(rd_empty), 1);
    check(ovr_flag == 1'b0, "R7", "read on empty overrun", int'(ovr_flag), 0);

    // R9: overrun with queueing enabled
    for (int k = 1; k <= 5; k++) rx_word(9'(k), 2'b00, 0, 0, 0, 1, -1, 2);
    @(negedge clk);
    check(ovr_flag == 1'b1, "R9", "overrun raised", int'(ovr_flag), 1);
    read_check("R9", 12'h001);
    read_check("R8", 12'h002);
    read_check("R8", 12'h003);
    read_check("R9", 12'h004);
    @(negedge clk);
    check(rd_empty == 1'b1, "R9", "fifth word dropped", int'(rd_empty), 1);
    check(ovr_flag == 1'b1, "R9", "overrun sticky", int'(ovr_flag), 1);
    clear_ovr();
    @(negedge clk);
    check(ovr_flag == 1'b0, "R9", "overrun cleared", int'(ovr_flag), 0);

    // R8: single holding entry
    set_fifo(1'b0);
    rx_word(9'h00C, 2'b00, 0, 0, 0, 1, -1, 2);
    rx_word(9'h00D, 2'b00, 0, 0, 0, 1, -1, 2);
    @(negedge clk);
    check(ovr_flag == 1'b1, "R8", "second word overflows", int'(ovr_flag), 1);
    read_check("R8", 12'h00C);
    @(negedge clk);
    check(rd_empty == 1'b1, "R8", "one entry only", int'(rd_empty), 1);
    clear_ovr();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule